// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the configuration port of a display controller. An external host reaches an 8-bit register file over three wires: an active-low chip select, a serial clock, and one data line that both sides share. Each transaction is a 16-bit frame sent most significant bit first. The frame starts with a 6-bit register address and a direction bit. Next comes one idle turnaround bit, and the frame ends with eight data bits. On a write the host drives the data bits. On a read the block drives them itself and leaves the line undriven the rest of the time.

The block runs on its own fast system clock. It passes the three serial inputs through a synchronizer and works from the detected edges, so the serial clock must be several times slower than the system clock. A write takes effect only when chip select is released after a complete frame. Three registers are protected: they accept writes only while two key registers both hold their unlock values. The register contents appear as parallel outputs for the rest of the controller.

Top module: `serRegSlave`

## Requirements
- R1: While `csN` is low, the block samples the line on each rising edge of `sclk`, most significant bit first. Frame bits 15..10 are the address and bit 9 is the direction (0 = write, 1 = read). A falling `csN` starts a new frame.
- R2: A write takes effect only on the release of `csN` after at least 16 rising edges. Clock edges after the 16th are ignored, and registers change at no other time.
- R3: On a read, the line stays released during frame bit 8. The block enables its driver on the falling `sclk` edge after the 8th rising edge and shifts out data bits 7..0, one per falling edge. It releases the line on the falling edge after the 16th rising edge, or when `csN` goes high.
- R4: During a write frame the block never drives the line, and the value of bit 8 has no effect.
- R5: Register 0x0E holds the first key, which is armed when it holds 0x5F. Register 0x0F holds the second key, which is armed when it holds 0xA4. Writing any other value disarms that key. Both key registers read back what was written.
- R6: Writes to registers 0x0D, 0x10 and 0x38 take effect only while both keys are armed. Otherwise they are dropped.
- R7: After reset, register 0x00 reads 0x0D: bit 0 (mode), bit 2 (global run) and bit 3 (standby release) are set, and bit 1 (clock polarity) is clear. Register 0x10 reads 0x01 and every other register reads 0x00.
- R8: If `csN` rises after fewer than 16 rising edges, the frame is discarded and no register changes.
- R9: The implemented addresses are 0x00, 0x01, 0x02, 0x03, 0x0D, 0x0E, 0x0F, 0x10 and 0x38. Writes to any other address are ignored, and reads of any other address return 0x00.
- R10: If the release of `csN` and a rising `sclk` edge are seen in the same synchronized cycle, that clock edge is not counted.
- R11: A read returns the current value of the addressed register, as it stands when the data phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdaIn | input | 1 | Value on the shared data line |
| sdaOut | output | 1 | Value the block drives during the read data phase |
| sdaOe | output | 1 | Driver enable for the shared data line |
| sysCtrl | output | 8 | Contents of register 0x00 |
| dispCtrl | output | 8 | Contents of register 0x01 |
| levelCtrl | output | 8 | Contents of register 0x02 |
| gateCtrl | output | 8 | Contents of register 0x03 |
| chargeTime | output | 8 | Contents of protected register 0x0D |
| inversion | output | 8 | Contents of protected register 0x10 |
| pwmDiv | output | 8 | Contents of protected register 0x38 |

## Verification
Two events can fall in the same synchronized cycle: the frame-end detection on the rise of chip select, and a serial clock rising edge that would complete the 16th bit. The bench provokes this by raising `csN` and `sclk` on the same system clock edge after fifteen bits of a write. The collision is judged by the register outputs staying unchanged, and then by a normal write to the same register succeeding. A second overlap is covered by the per-cycle model: a key write and a protected write in successive frames, with the protected register's outputs compared on every clock.

// File: rtl/serRegPkg.sv
package serRegPkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 16;

  localparam logic [ADDR_W-1:0] A_SYS   = 6'h00;
  localparam logic [ADDR_W-1:0] A_DISP  = 6'h01;
  localparam logic [ADDR_W-1:0] A_LEVEL = 6'h02;
  localparam logic [ADDR_W-1:0] A_GATE  = 6'h03;
  localparam logic [ADDR_W-1:0] A_CHG   = 6'h0D;
  localparam logic [ADDR_W-1:0] A_KEY1  = 6'h0E;
  localparam logic [ADDR_W-1:0] A_KEY2  = 6'h0F;
  localparam logic [ADDR_W-1:0] A_INV   = 6'h10;
  localparam logic [ADDR_W-1:0] A_PWM   = 6'h38;

  localparam logic [DATA_W-1:0] KEY1_VAL = 8'h5F;
  localparam logic [DATA_W-1:0] KEY2_VAL = 8'hA4;

  // strobes from the frame control to the datapath
  typedef struct packed {
    logic shiftIn;   // capture one line bit
    logic hdrLatch;  // address complete, hold it
    logic loadOut;   // start of read data phase
    logic shiftOut;  // next read data bit
    logic driveOff;  // release the line
    logic commit;    // complete write frame ended
  } strobe_t;

  function automatic logic isImpl(input logic [ADDR_W-1:0] a);
    case (a)
      A_SYS, A_DISP, A_LEVEL, A_GATE, A_CHG,
      A_KEY1, A_KEY2, A_INV, A_PWM: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic isProt(input logic [ADDR_W-1:0] a);
    return (a == A_CHG) || (a == A_INV) || (a == A_PWM);
  endfunction

  function automatic logic [DATA_W-1:0] rstVal(input logic [ADDR_W-1:0] a);
    case (a)
      A_SYS:   return 8'h0D;
      A_INV:   return 8'h01;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/serRegSync.sv
module serRegSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/serRegEdge.sv
module serRegEdge #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= RST_VAL;
    else       prevLvl <= lvl;
  end

  assign rise = lvl & ~prevLvl;
  assign fall = ~lvl & prevLvl;
endmodule

// File: rtl/serRegCtrl.sv
module serRegCtrl
  import serRegPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int FW = FRAME_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csLvl,
  input  logic    csRise,
  input  logic    csFall,
  input  logic    sclkRise,
  input  logic    sclkFall,
  input  logic    sdaLvl,
  output strobe_t stb,
  output logic    isRead
);
  localparam int CNT_W = $clog2(FW + 1);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FW);
  localparam logic [CNT_W-1:0] DIR_POS  = CNT_W'(AW);
  localparam logic [CNT_W-1:0] LOAD_POS = CNT_W'(AW + 2);

  logic [CNT_W-1:0] bitCnt;
  logic             active;

  assign active = ~csLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      isRead <= 1'b0;
    end else if (csLvl || csFall) begin
      bitCnt <= '0;
      isRead <= 1'b0;
    end else if (sclkRise && bitCnt != LAST) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == DIR_POS) isRead <= sdaLvl;
    end
  end

  always_comb begin
    stb          = '0;
    stb.shiftIn  = active & sclkRise & (bitCnt != LAST);
    stb.hdrLatch = active & sclkRise & (bitCnt == DIR_POS);
    stb.loadOut  = active & sclkFall & isRead & (bitCnt == LOAD_POS);
    stb.shiftOut = active & sclkFall & isRead & (bitCnt > LOAD_POS) & (bitCnt < LAST);
    stb.driveOff = ~active | (sclkFall & (bitCnt == LAST));
    stb.commit   = csRise & (bitCnt == LAST) & ~isRead;
  end
endmodule

// File: rtl/serRegData.sv
module serRegData
  import serRegPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          sdaLvl,
  output logic          sdaOut,
  output logic          sdaOe,
  output logic          unlocked,
  output logic [DW-1:0] sysCtrl,
  output logic [DW-1:0] dispCtrl,
  output logic [DW-1:0] levelCtrl,
  output logic [DW-1:0] gateCtrl,
  output logic [DW-1:0] chargeTime,
  output logic [DW-1:0] inversion,
  output logic [DW-1:0] pwmDiv
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] shReg;
  logic [DW-1:0] outSh;
  logic [AW-1:0] addrQ;
  logic [DW-1:0] regQ [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      addrQ <= '0;
    end else begin
      if (stb.hdrLatch) addrQ <= shReg[AW-1:0];
      if (stb.shiftIn)  shReg <= {shReg[DW-2:0], sdaLvl};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSh <= '0;
      sdaOe <= 1'b0;
    end else if (stb.driveOff) begin
      sdaOe <= 1'b0;
    end else if (stb.loadOut) begin
      outSh <= regQ[addrQ];
      sdaOe <= 1'b1;
    end else if (stb.shiftOut) begin
      outSh <= {outSh[DW-2:0], 1'b0};
    end
  end

  assign sdaOut   = outSh[DW-1];
  assign unlocked = (regQ[A_KEY1] == KEY1_VAL) && (regQ[A_KEY2] == KEY2_VAL);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [AW-1:0] SLOT = AW'(g);
    if (isImpl(SLOT)) begin : g_impl
      logic wrHit;
      assign wrHit = stb.commit && (addrQ == SLOT) && (!isProt(SLOT) || unlocked);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      regQ[g] <= rstVal(SLOT);
        else if (wrHit) regQ[g] <= shReg;
      end
    end else begin : g_none
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regQ[g] <= '0;
        else       regQ[g] <= '0;
      end
    end
  end

  assign sysCtrl    = regQ[A_SYS];
  assign dispCtrl   = regQ[A_DISP];
  assign levelCtrl  = regQ[A_LEVEL];
  assign gateCtrl   = regQ[A_GATE];
  assign chargeTime = regQ[A_CHG];
  assign inversion  = regQ[A_INV];
  assign pwmDiv     = regQ[A_PWM];
endmodule

// File: rtl/serRegSlave.sv
module serRegSlave
  import serRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic [DATA_W-1:0] sysCtrl,
  output logic [DATA_W-1:0] dispCtrl,
  output logic [DATA_W-1:0] levelCtrl,
  output logic [DATA_W-1:0] gateCtrl,
  output logic [DATA_W-1:0] chargeTime,
  output logic [DATA_W-1:0] inversion,
  output logic [DATA_W-1:0] pwmDiv
);
  logic [2:0] syncLvl;
  logic [1:0] edgeRise, edgeFall;
  logic       csLvl, sclkLvl, sdaLvl;
  logic       csRise, csFall, sclkRise, sclkFall;
  logic       isRead, unlocked;
  strobe_t    stb;

  serRegSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk(clk), .rstN(rstN), .din({sdaIn, sclk, csN}), .lvl(syncLvl)
  );

  assign csLvl   = syncLvl[0];
  assign sclkLvl = syncLvl[1];
  assign sdaLvl  = syncLvl[2];

  serRegEdge #(.WIDTH(2), .RST_VAL(2'b01)) u_edge (
    .clk(clk), .rstN(rstN), .lvl({sclkLvl, csLvl}), .rise(edgeRise), .fall(edgeFall)
  );

  assign csRise   = edgeRise[0];
  assign csFall   = edgeFall[0];
  assign sclkRise = edgeRise[1];
  assign sclkFall = edgeFall[1];

  serRegCtrl #(.AW(ADDR_W), .FW(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csLvl(csLvl), .csRise(csRise), .csFall(csFall),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .sdaLvl(sdaLvl),
    .stb(stb), .isRead(isRead)
  );

  serRegData #(.AW(ADDR_W), .DW(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .unlocked(unlocked),
    .sysCtrl(sysCtrl), .dispCtrl(dispCtrl), .levelCtrl(levelCtrl), .gateCtrl(gateCtrl),
    .chargeTime(chargeTime), .inversion(inversion), .pwmDiv(pwmDiv)
  );
endmodule

// File: rtl/serRegChk.sv
module serRegChk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          sdaOe,
  input logic          csLvl,
  input logic          csRise,
  input logic          sclkFall,
  input logic          isRead,
  input logic          unlocked,
  input logic [DW-1:0] sysCtrl,
  input logic [DW-1:0] dispCtrl,
  input logic [DW-1:0] levelCtrl,
  input logic [DW-1:0] gateCtrl,
  input logic [DW-1:0] chargeTime,
  input logic [DW-1:0] inversion,
  input logic [DW-1:0] pwmDiv
);
  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    csLvl |=> !sdaOe);

  p_drive_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(sclkFall));

  p_write_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> isRead);

  p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable({chargeTime, inversion, pwmDiv}));

  p_commit_at_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csRise |=> $stable({sysCtrl, dispCtrl, levelCtrl, gateCtrl, chargeTime, inversion, pwmDiv}));
endmodule

bind serRegSlave serRegChk #(.DW(serRegPkg::DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .csLvl(csLvl), .csRise(csRise),
  .sclkFall(sclkFall), .isRead(isRead), .unlocked(unlocked),
  .sysCtrl(sysCtrl), .dispCtrl(dispCtrl), .levelCtrl(levelCtrl), .gateCtrl(gateCtrl),
  .chargeTime(chargeTime), .inversion(inversion), .pwmDiv(pwmDiv)
);

// File: tb/serRegSlave_tb_top.sv
module serRegSlave_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, csN, sclk, mstEn, mstBit, line;
  logic sdaOut, sdaOe;
  logic [7:0] sysCtrl, dispCtrl, levelCtrl, gateCtrl, chargeTime, inversion, pwmDiv;

  assign line = sdaOe ? sdaOut : (mstEn ? mstBit : 1'b1);

  serRegSlave dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdaIn(line),
    .sdaOut(sdaOut), .sdaOe(sdaOe),
    .sysCtrl(sysCtrl), .dispCtrl(dispCtrl), .levelCtrl(levelCtrl), .gateCtrl(gateCtrl),
    .chargeTime(chargeTime), .inversion(inversion), .pwmDiv(pwmDiv)
  );

  int compared = 0;
  int mismatched = 0;
  bit blank = 1'b1;
  bit inWrite = 1'b0;
  bit done = 1'b0;
  int mreg [64];

  function automatic bit modelImpl(int a);
    return a inside {'h00, 'h01, 'h02, 'h03, 'h0D, 'h0E, 'h0F, 'h10, 'h38};
  endfunction

  function automatic bit modelProt(int a);
    return a inside {'h0D, 'h10, 'h38};
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 64; i++) mreg[i] = 0;
    mreg['h00] = 'h0D;
    mreg['h10] = 'h01;
  endtask

  task automatic modelWrite(int a, int d);
    if (!modelImpl(a)) return;
    if (modelProt(a) && !(mreg['h0E] == 'h5F && mreg['h0F] == 'hA4)) return;
    mreg[a] = d & 'hFF;
  endtask

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  // per-cycle comparison against the behavioural register model
  always @(negedge clk) begin
    if (rstN && !blank && !done) begin
      chk("R2 sysCtrl", sysCtrl, mreg['h00]);
      chk("R2 dispCtrl", dispCtrl, mreg['h01]);
      chk("R2 levelCtrl", levelCtrl, mreg['h02]);
      chk("R2 gateCtrl", gateCtrl, mreg['h03]);
      chk("R6 chargeTime", chargeTime, mreg['h0D]);
      chk("R6 inversion", inversion, mreg['h10]);
      chk("R6 pwmDiv", pwmDiv, mreg['h38]);
      chk("R3 no bus contention", int'(sdaOe && mstEn), 0);
      chk("R4 no drive in write frame", int'(inWrite && sdaOe), 0);
    end
  end

  task automatic frame(input int addr, input bit rd, input bit ta, input int wdata,
                       input int nclk, input bit coinc, output logic [7:0] got);
    logic [15:0] word;
    word = {addr[5:0], rd, ta, wdata[7:0]};
    got = '0;
    inWrite = !rd;
    mstEn = 1'b1;
    mstBit = 1'b0;
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nclk; i++) begin
      if (rd && i >= 7) mstEn = 1'b0;
      else begin
        mstEn = 1'b1;
        mstBit = (i < 16) ? word[15-i] : 1'b0;
      end
      waitClk(HALF);
      if (rd && i == 7) chk("R3 line released in turnaround", int'(sdaOe), 0);
      if (rd && i >= 8 && i < 16) begin
        chk("R3 slave drives data phase", int'(sdaOe), 1);
        got[15-i] = line;
      end
      if (coinc && i == nclk - 1) begin
        sclk = 1'b1;
        csN = 1'b1;
        waitClk(HALF);
      end else begin
        sclk = 1'b1;
        waitClk(HALF);
        sclk = 1'b0;
      end
    end
    if (!coinc) waitClk(HALF);
    blank = 1'b1;
    csN = 1'b1;
    mstEn = 1'b0;
    waitClk(6);
    if (!rd && nclk >= 16 && !coinc) modelWrite(addr, wdata);
    sclk = 1'b0;
    blank = 1'b0;
    inWrite = 1'b0;
    waitClk(HALF);
    chk("R3 line released after frame", int'(sdaOe), 0);
  endtask

  task automatic wr(int a, int d);
    logic [7:0] dummy;
    frame(a, 1'b0, 1'b0, d, 16, 1'b0, dummy);
  endtask

  task automatic rdChk(int a, int exp, string req);
    logic [7:0] got;
    frame(a, 1'b1, 1'b0, 0, 16, 1'b0, got);
    chk(req, got, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual 0 expected 1");
      finishRun();
    end
  end

  initial begin
    logic [7:0] dummy;
    modelReset();
    rstN = 1'b0;
    csN = 1'b1;
    sclk = 1'b0;
    mstEn = 1'b0;
    mstBit = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);

    // R7 reset state at the ports
    chk("R7 reset sysCtrl", sysCtrl, 'h0D);
    chk("R7 reset inversion", inversion, 'h01);
    chk("R7 reset pwmDiv", pwmDiv, 'h00);
    chk("R7 reset sdaOe", int'(sdaOe), 0);
    blank = 1'b0;

    // R7 / R11 read of reset values through the serial port
    rdChk('h00, 'h0D, "R7 R11 read reset reg 0x00");
    rdChk('h10, 'h01, "R7 R11 read reset reg 0x10");

    // R1 / R4 write with turnaround bit set, then read back
    frame('h01, 1'b0, 1'b1, 'hA5, 16, 1'b0, dummy);
    chk("R1 R4 write lands", dispCtrl, 'hA5);
    rdChk('h01, 'hA5, "R11 read back 0x01");
    wr('h03, 'h3C);
    chk("R1 write reg 0x03", gateCtrl, 'h3C);

    // R6 locked protected writes
    wr('h10, 'h41);
    chk("R6 locked write dropped", inversion, 'h01);
    wr('h0E, 'h5F);
    wr('h10, 'h41);
    chk("R6 one key is not enough", inversion, 'h01);
    wr('h0F, 'hA4);
    wr('h10, 'h41);
    chk("R6 unlocked write 0x10", inversion, 'h41);
    wr('h38, 'h7C);
    chk("R6 unlocked write 0x38", pwmDiv, 'h7C);
    wr('h0D, 'h33);
    chk("R6 unlocked write 0x0D", chargeTime, 'h33);

    // R5 key read back and disarm
    rdChk('h0E, 'h5F, "R5 key1 read back");
    rdChk('h0F, 'hA4, "R5 key2 read back");
    wr('h0E, 'h5E);
    wr('h10, 'h22);
    chk("R5 wrong key disarms", inversion, 'h41);
    wr('h0E, 'h5F);
    wr('h38, 'h1C);
    chk("R5 rearmed key unlocks", pwmDiv, 'h1C);
    wr('h0F, 'h00);
    wr('h0D, 'h99);
    chk("R5 key2 cleared locks", chargeTime, 'h33);

    // R8 short frames discarded
    frame('h02, 1'b0, 1'b0, 'hF0, 12, 1'b0, dummy);
    chk("R8 12-clock frame discarded", levelCtrl, 'h00);
    frame('h02, 1'b0, 1'b0, 'hF0, 15, 1'b0, dummy);
    chk("R8 15-clock frame discarded", levelCtrl, 'h00);

    // R2 extra clocks after the 16th are ignored
    frame('h03, 1'b0, 1'b0, 'h5A, 18, 1'b0, dummy);
    chk("R2 long frame keeps 16-bit data", gateCtrl, 'h5A);

    // R10 coincident chip select release and clock edge
    frame('h02, 1'b0, 1'b0, 'hC3, 16, 1'b1, dummy);
    chk("R10 coincident edge not counted", levelCtrl, 'h00);
    wr('h02, 'hC3);
    chk("R10 following write accepted", levelCtrl, 'hC3);

    // R9 unimplemented addresses
    wr('h05, 'hFF);
    rdChk('h05, 'h00, "R9 unimplemented read 0x05");
    rdChk('h3F, 'h00, "R9 unimplemented read 0x3F");
    rdChk('h02, 'hC3, "R11 read back 0x02");
    rdChk('h38, 'h1C, "R11 read back protected 0x38");

    waitClk(10);
    finishRun();
  end
endmodule